// File: doc/BRIEF.md
# Command-Sequence Write Unlock Guard

This block sits beside the page-load logic of a byte-wide nonvolatile memory. It watches every write cycle on the parallel bus. A data write may reach the array only when a fixed run of command writes comes immediately before it. Each command write must carry a set address and a set data value. Both the run length and the address/data pairs are parameters.

For every accepted write, the guard reports in the same cycle whether it is a command write or a data write. A command write is consumed, and its data is never stored. A data write opens or extends the current load, which starts or restarts the page controller's byte-load timer.

The guard drives a commit-enable level. The page controller samples it when the load window closes. If the command run was incomplete, the load still runs its full programming period, but nothing is stored.

While the load or its programming period is active, a poll indicator tells the read path to return status instead of array data. After each programming cycle ends, including a cycle that loaded no bytes, the guard locks again. The next write operation therefore needs the full command run once more.

Top module: `command_unlock_guard`

## Requirements
- R1: After reset, `cmdMark`, `dataMark`, `commitEn` and `pollMode` are all 0.
- R2: When no load is in progress, a write whose full address and data equal command step k is a command write, where k is the number of steps already matched (0 at first). Its `cmdMark` is 1 and its `dataMark` is 0 in the strobe cycle. Step k occupies slice k of the `CMD_ADDR`/`CMD_DATA` parameters, with step 0 in the least significant slice.
- R3: `commitEn` goes to 1 in the cycle after the last command step is matched. It stays at 1 through the load and the programming period that follows.
- R4: While the command run is still incomplete, a write that does not match the expected step is a data write. It shows `dataMark`=1 and `cmdMark`=0. It sends the matcher back to step 0, and the load it starts keeps `commitEn` at 0.
- R5: Unlocking does not persist. In the cycle after `progDone` ends a programming period, `commitEn` and `pollMode` are 0, and the next write without a command run is a locked data write.
- R6: A `loadExpire` pulse that arrives after one or more command steps have matched, but before the run is complete, drops the partial match. The next write is then compared against step 0.
- R7: In any state where the byte-load window is open (partial match, unlocked load, or locked load), a `loadExpire` in the same cycle as `wrStrobe` suppresses that write. Both marks are 0.
- R8: Once unlocked, every write is a data write, even one whose address and data equal a command step. `commitEn` stays at 1 throughout.
- R9: `pollMode` becomes 1 in the cycle after the first data write of a load. It is also 1 throughout the programming period, including an empty one that started from an unlocked state with no data written.
- R10: During the programming period, writes are ignored and both marks stay 0. A `progDone` pulse outside the programming period has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStrobe | input | 1 | One-cycle pulse per bus write |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| loadExpire | input | 1 | Byte-load window elapsed, from the load timer |
| progDone | input | 1 | Programming period finished |
| cmdMark | output | 1 | Current write is a command write |
| dataMark | output | 1 | Current write is a data write (starts or restarts the load timer) |
| commitEn | output | 1 | Loaded bytes may be committed to the array |
| pollMode | output | 1 | Reads must return status instead of data |

## Verification
The bench takes a small configuration and, for each step of the command run, tries every address and data pair. This catches two kinds of error: a matcher that compares only the address or a partial field, and one that accepts steps out of order. Either would let a wrong write open the gate or turn a real command into a stored byte.

Directed cases cover four corner cases. The first is an expire arriving in the same cycle as a write; a design that got this wrong would still count the write. The second is an expire in the middle of the run; getting it wrong leaves a stale partial match. The third is an unlocked load that holds no bytes; getting it wrong never relocks. The last is a second operation after `progDone`; a design with a sticky unlock would let that write through.

// File: rtl/unlock_guard_pkg.sv
package unlock_guard_pkg;

  typedef enum logic [1:0] {
    GS_SEQ      = 2'd0,
    GS_OPEN     = 2'd1,
    GS_LOCKLOAD = 2'd2,
    GS_BUSY     = 2'd3
  } guardState_e;

  typedef struct packed {
    logic openGate;
    logic dataWrite;
    logic relock;
    logic busy;
  } guardStrobe_t;

endpackage

// File: rtl/ug_datapath.sv
module ug_datapath
  import unlock_guard_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int SEQ_LEN = 3,
  parameter logic [SEQ_LEN*ADDR_W-1:0] CMD_ADDR = '0,
  parameter logic [SEQ_LEN*DATA_W-1:0] CMD_DATA = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  guardStrobe_t       strb,
  output logic [SEQ_LEN-1:0] stepMatch,
  output logic               commitEn,
  output logic               pollMode
);

  logic commitQ;
  logic loadQ;

  // one full-width comparator per command step
  for (genvar g = 0; g < SEQ_LEN; g++) begin : g_step
    assign stepMatch[g] = (wrAddr == CMD_ADDR[g*ADDR_W +: ADDR_W]) &&
                          (wrData == CMD_DATA[g*DATA_W +: DATA_W]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitQ <= 1'b0;
      loadQ   <= 1'b0;
    end else if (strb.relock) begin
      commitQ <= 1'b0;
      loadQ   <= 1'b0;
    end else begin
      if (strb.openGate)  commitQ <= 1'b1;
      if (strb.dataWrite) loadQ   <= 1'b1;
    end
  end

  assign commitEn = commitQ;
  assign pollMode = loadQ | strb.busy;

  // R2: the gate may only open on a write matching the final step
  p_gate_needs_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.openGate |-> stepMatch[SEQ_LEN-1]);

endmodule

// File: rtl/ug_control.sv
module ug_control
  import unlock_guard_pkg::*;
#(
  parameter int SEQ_LEN = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrStrobe,
  input  logic               loadExpire,
  input  logic               progDone,
  input  logic [SEQ_LEN-1:0] stepMatch,
  output logic               cmdMark,
  output logic               dataMark,
  output guardStrobe_t       strb
);

  localparam int CNT_W = $clog2(SEQ_LEN + 1);

  guardState_e state;
  logic [CNT_W-1:0] stepCnt;
  logic curHit;
  logic inWindow;
  logic expireNow;
  logic takeWrite;
  logic lastStep;

  always_comb begin
    curHit = 1'b0;
    for (int i = 0; i < SEQ_LEN; i++) begin
      if (stepCnt == CNT_W'(i)) curHit = stepMatch[i];
    end
  end

  assign inWindow  = (state == GS_SEQ && stepCnt != '0) ||
                     state == GS_OPEN || state == GS_LOCKLOAD;
  assign expireNow = loadExpire && inWindow;
  assign takeWrite = wrStrobe && !expireNow && (state != GS_BUSY);
  assign cmdMark   = takeWrite && (state == GS_SEQ) && curHit;
  assign dataMark  = takeWrite && !cmdMark;
  assign lastStep  = (stepCnt == CNT_W'(SEQ_LEN - 1));

  always_comb begin
    strb.openGate  = cmdMark && lastStep;
    strb.dataWrite = dataMark;
    strb.relock    = (state == GS_BUSY) && progDone;
    strb.busy      = (state == GS_BUSY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= GS_SEQ;
      stepCnt <= '0;
    end else begin
      unique case (state)
        GS_SEQ: begin
          if (expireNow) begin
            stepCnt <= '0;
          end else if (cmdMark) begin
            if (lastStep) begin
              state   <= GS_OPEN;
              stepCnt <= '0;
            end else begin
              stepCnt <= stepCnt + 1'b1;
            end
          end else if (dataMark) begin
            state   <= GS_LOCKLOAD;
            stepCnt <= '0;
          end
        end
        GS_OPEN, GS_LOCKLOAD: begin
          if (expireNow) state <= GS_BUSY;
        end
        GS_BUSY: begin
          if (progDone) state <= GS_SEQ;
        end
        default: state <= GS_SEQ;
      endcase
    end
  end

  // R2: a write is never both command and data
  p_marks_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdMark && dataMark));

  // R2: step counter never leaves the run
  p_count_in_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    stepCnt <= CNT_W'(SEQ_LEN - 1));

  // R10: programming period ignores bus writes
  p_busy_silent_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == GS_BUSY) |-> (!cmdMark && !dataMark));

  // R6: an expire during a partial match returns to step 0
  p_expire_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == GS_SEQ && expireNow) |=> (stepCnt == '0));

endmodule

// File: rtl/command_unlock_guard.sv
module command_unlock_guard
  import unlock_guard_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int SEQ_LEN = 3,
  parameter logic [SEQ_LEN*ADDR_W-1:0] CMD_ADDR = {15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [SEQ_LEN*DATA_W-1:0] CMD_DATA = {8'hA0, 8'h55, 8'hAA}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loadExpire,
  input  logic              progDone,
  output logic              cmdMark,
  output logic              dataMark,
  output logic              commitEn,
  output logic              pollMode
);

  guardStrobe_t strb;
  logic [SEQ_LEN-1:0] stepMatch;

  ug_control #(.SEQ_LEN(SEQ_LEN)) u_ctl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .loadExpire(loadExpire),
    .progDone(progDone), .stepMatch(stepMatch), .cmdMark(cmdMark),
    .dataMark(dataMark), .strb(strb)
  );

  ug_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_LEN(SEQ_LEN),
    .CMD_ADDR(CMD_ADDR), .CMD_DATA(CMD_DATA)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData), .strb(strb),
    .stepMatch(stepMatch), .commitEn(commitEn), .pollMode(pollMode)
  );

  // R3: commit opens only right after a command write
  p_commit_after_cmd_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(commitEn) |-> $past(cmdMark));

  // R5: finishing a programming period relocks
  p_done_relocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && progDone) |=> (!commitEn && !pollMode));

  // R9: a data write turns on status polling
  p_data_polls_r9: assert property (@(posedge clk) disable iff (!rstN)
    dataMark |=> pollMode);

endmodule

// File: tb/sim_command_unlock_guard.sv
`timescale 1ns/1ps
module sim_command_unlock_guard;

  localparam int AW = 4;
  localparam int DW = 2;
  localparam int SL = 3;
  localparam logic [SL*AW-1:0] CA = {4'h5, 4'hA, 4'h5};
  localparam logic [SL*DW-1:0] CD = {2'd0, 2'd1, 2'd2};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStrobe = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic loadExpire = 1'b0;
  logic progDone = 1'b0;
  logic cmdMark, dataMark, commitEn, pollMode;

  int nChecks = 0;
  int nFail = 0;
  logic sCmd, sData;

  always #10 clk = ~clk;

  command_unlock_guard #(
    .ADDR_W(AW), .DATA_W(DW), .SEQ_LEN(SL), .CMD_ADDR(CA), .CMD_DATA(CD)
  ) u0 (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .loadExpire(loadExpire), .progDone(progDone),
    .cmdMark(cmdMark), .dataMark(dataMark), .commitEn(commitEn),
    .pollMode(pollMode)
  );

  function automatic int caOf(int s); return int'(CA[s*AW +: AW]); endfunction
  function automatic int cdOf(int s); return int'(CD[s*DW +: DW]); endfunction

  task automatic chk(input string tag, input int act, input int expv);
    nChecks++;
    if (act != expv) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // drive one cycle of inputs at negedge, sample combinational marks mid-cycle
  task automatic cyc(input logic w, input int a, input int d,
                     input logic ex, input logic dn);
    @(negedge clk);
    wrStrobe = w; wrAddr = AW'(a); wrData = DW'(d);
    loadExpire = ex; progDone = dn;
    #5;
    sCmd = cmdMark; sData = dataMark;
    @(posedge clk);
    #5;
    wrStrobe = 1'b0; loadExpire = 1'b0; progDone = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #5;
    rstN = 1'b1;
  endtask

  task automatic unlockAll();
    for (int s = 0; s < SL; s++) begin
      wr(caOf(s), cdOf(s));
      chk("R2 cmd step", int'(sCmd), 1);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #5;
    // R1 reset state
    chk("R1 cmdMark", int'(cmdMark), 0);
    chk("R1 dataMark", int'(dataMark), 0);
    chk("R1 commitEn", int'(commitEn), 0);
    chk("R1 pollMode", int'(pollMode), 0);
    rstN = 1'b1;

    // sweep: every address/data at each step of the run (R2, R3, R4)
    for (int s = 0; s < SL; s++) begin
      for (int a = 0; a < (1 << AW); a++) begin
        for (int d = 0; d < (1 << DW); d++) begin
          bit hit;
          doReset();
          for (int p = 0; p < s; p++) wr(caOf(p), cdOf(p));
          hit = (a == caOf(s)) && (d == cdOf(s));
          wr(a, d);
          chk("R2 sweep cmdMark", int'(sCmd), int'(hit));
          chk("R4 sweep dataMark", int'(sData), int'(!hit));
          chk("R3 sweep commitEn", int'(commitEn), int'(hit && s == SL - 1));
          chk("R4 sweep pollMode", int'(pollMode), int'(!hit));
        end
      end
    end

    // R8, R9, R10, R5: full unlocked operation
    doReset();
    unlockAll();
    chk("R3 commit after run", int'(commitEn), 1);
    chk("R9 no poll before data", int'(pollMode), 0);
    wr(caOf(0), cdOf(0));
    chk("R8 cmd value is data", int'(sData), 1);
    chk("R8 cmd value no cmdMark", int'(sCmd), 0);
    chk("R8 commit held", int'(commitEn), 1);
    chk("R9 poll after data", int'(pollMode), 1);
    wr(3, 3);
    chk("R8 second data", int'(sData), 1);
    cyc(1'b0, 0, 0, 1'b1, 1'b0);
    chk("R3 commit in busy", int'(commitEn), 1);
    chk("R9 poll in busy", int'(pollMode), 1);
    wr(caOf(0), cdOf(0));
    chk("R10 busy no cmdMark", int'(sCmd), 0);
    chk("R10 busy no dataMark", int'(sData), 0);
    cyc(1'b0, 0, 0, 1'b0, 1'b1);
    chk("R5 commit relocked", int'(commitEn), 0);
    chk("R5 poll cleared", int'(pollMode), 0);
    wr(3, 3);
    chk("R5 plain write is data", int'(sData), 1);
    chk("R5 plain write locked", int'(commitEn), 0);

    // R7 and R6: same-cycle expire, then stale partial match
    doReset();
    wr(caOf(0), cdOf(0));
    cyc(1'b1, caOf(1), cdOf(1), 1'b1, 1'b0);
    chk("R7 suppressed cmdMark", int'(sCmd), 0);
    chk("R7 suppressed dataMark", int'(sData), 0);
    wr(caOf(1), cdOf(1));
    chk("R6 step1 after expire is data", int'(sData), 1);

    doReset();
    wr(caOf(0), cdOf(0));
    wr(caOf(1), cdOf(1));
    cyc(1'b0, 0, 0, 1'b1, 1'b0);
    wr(caOf(2), cdOf(2));
    chk("R6 step2 after expire not cmd", int'(sCmd), 0);
    chk("R6 step2 after expire is data", int'(sData), 1);
    chk("R6 no commit", int'(commitEn), 0);

    // R7 in an open load: expire wins over write
    doReset();
    unlockAll();
    cyc(1'b1, 1, 1, 1'b1, 1'b0);
    chk("R7 open suppressed", int'(sData), 0);
    chk("R9 empty busy polls", int'(pollMode), 1);

    // R10 stray done, then empty cycle relock (R9, R5)
    doReset();
    unlockAll();
    cyc(1'b0, 0, 0, 1'b0, 1'b1);
    chk("R10 stray done ignored", int'(commitEn), 1);
    cyc(1'b0, 0, 0, 1'b1, 1'b0);
    chk("R9 empty cycle poll", int'(pollMode), 1);
    chk("R3 empty cycle commit", int'(commitEn), 1);
    cyc(1'b0, 0, 0, 1'b0, 1'b1);
    chk("R5 empty cycle relock", int'(commitEn), 0);
    chk("R5 empty cycle poll off", int'(pollMode), 0);
    wr(caOf(0), cdOf(0));
    chk("R5 new run starts at step0", int'(sCmd), 1);

    report();
    $finish;
  end

endmodule